// File: doc/BRIEF.md
# Ping-Pong Orientation Transpose Buffer

This block sits between the first and second 1-D passes of a fully parallel 2-D transform. On every accepted cycle it takes one N-lane vector from the first pass and returns one N-lane vector to the second pass. Each output is one vector of the transpose of the N-vector block written before it.

The storage is a single N x N array of register cells. For N accepted vectors the buffer writes and reads in one orientation (columns), and for the next N it uses the other orientation (rows). It keeps alternating between the two. In each cycle the cell line that is read out is the same line that the incoming vector overwrites. Data therefore never moves inside the array and no second bank is needed.

Each cell chooses its input lane with a two-way multiplexer. Each output lane i is picked from the 2N-1 cells that lie on row i or column i. A lane counter and an orientation flag advance only when a vector is accepted, so gaps in the input stream simply freeze the buffer.

Top module: `xpose_pp_top`

## Requirements
- R1: Reset clears the buffer: `out_valid` is 0 and `out_data` is all zeros immediately after reset.
- R2: The first N accepted vectors after reset produce no valid output. The first valid output appears one clock after the (N+1)th accepted vector.
- R3: Number the accepted vectors from 0 since reset, and let n = N*b + k with 0 <= k < N. For b >= 1, output lane i (bits i*W +: W) produced for vector n equals lane k of accepted vector N*(b-1) + i. Each output block is therefore the transpose of the previous input block.
- R4: Once the buffer is filled, back-to-back accepted vectors yield one valid output per clock. Blocks of both orientation parities transpose correctly without any idle cycle between blocks.
- R5: A cycle with `in_valid` low changes no state. The next clock shows `out_valid` at 0, and the data sequence resumes unchanged when input returns, including in the middle of a block.
- R6: While `out_valid` is 0 following a cycle with no accepted input, `out_data` keeps its previous value.
- R7: A reset applied in the middle of a stream restarts the fill: R2 applies again from that reset.
- R8: Once the buffer is filled, every accepted vector gives `out_valid` at 1 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input vector is accepted this cycle |
| in_data | input | N*W | Input vector, lane i at bits i*W +: W |
| out_valid | output | 1 | Output vector is valid |
| out_data | output | N*W | Transposed output vector, lane i at bits i*W +: W |

## Verification
The assertions assume that `in_valid` is always a known level after reset. They also assume that accepted vectors arrive as a plain stream with no notion of block start other than the count since reset. Any valid cycle counts toward the current block. The stimulus drives inputs only at falling edges and holds `rst_n` low for whole cycles. It inserts idle cycles at arbitrary points inside blocks, so the lane count carries across the gaps as these assumptions require.

// File: rtl/xpose_pp_pkg.sv
package xpose_pp_pkg;

    typedef enum logic {
        ORI_COL = 1'b0,
        ORI_ROW = 1'b1
    } ori_e;

endpackage

// File: rtl/xpose_pp_seq.sv
module xpose_pp_seq
    import xpose_pp_pkg::*;
#(
    parameter int N  = 4,
    parameter int CW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [CW-1:0] lane,
    output ori_e          ori,
    output logic          primed
);

    localparam logic [CW-1:0] LAST = CW'(N - 1);

    typedef struct packed {
        logic [CW-1:0] lane;
        ori_e          ori;
        logic          primed;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv) begin
            if (st_q.lane == LAST) begin
                st_d.lane   = '0;
                st_d.ori    = (st_q.ori == ORI_COL) ? ORI_ROW : ORI_COL;
                st_d.primed = 1'b1;
            end else begin
                st_d.lane = st_q.lane + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{lane: '0, ori: ORI_COL, primed: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign lane   = st_q.lane;
    assign ori    = st_q.ori;
    assign primed = st_q.primed;

endmodule

// File: rtl/xpose_pp_cell.sv
module xpose_pp_cell
    import xpose_pp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  ori_e         ori,
    input  logic [W-1:0] by_row_lane,
    input  logic [W-1:0] by_col_lane,
    output logic [W-1:0] q
);

    logic [W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (we) begin
            val_d = (ori == ORI_COL) ? by_row_lane : by_col_lane;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
        end else begin
            val_q <= val_d;
        end
    end

    assign q = val_q;

endmodule

// File: rtl/xpose_pp_pick.sv
module xpose_pp_pick
    import xpose_pp_pkg::*;
#(
    parameter int N  = 4,
    parameter int W  = 8,
    parameter int I  = 0,
    parameter int CW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N*W-1:0] row_cells,
    input  logic [N*W-1:0] col_cells,
    input  logic [CW-1:0]  lane,
    input  ori_e           ori,
    output logic [W-1:0]   q
);

    localparam int NSRC = 2 * N - 1;

    logic [W-1:0] src [NSRC];

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_row
            assign src[g] = row_cells[g*W +: W];
        end
        for (g = 0; g < N - 1; g++) begin : g_col
            localparam int R = (g < I) ? g : g + 1;
            assign src[N + g] = col_cells[R*W +: W];
        end
    endgenerate

    always_comb begin
        int k;
        int sel;
        k = int'(lane);
        if (ori == ORI_COL || k == I) begin
            sel = k;
        end else begin
            sel = N + ((k < I) ? k : k - 1);
        end
        q = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (s == sel) begin
                q = src[s];
            end
        end
    end

endmodule

// File: rtl/xpose_pp_top.sv
module xpose_pp_top
    import xpose_pp_pkg::*;
#(
    parameter int N = 4,
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [N*W-1:0] in_data,
    output logic           out_valid,
    output logic [N*W-1:0] out_data
);

    localparam int CW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic           vld;
        logic [N*W-1:0] dat;
    } oreg_t;

    logic [CW-1:0] lane;
    ori_e          ori;
    logic          primed;
    logic [W-1:0]  cell_q [N][N];
    logic [N*W-1:0] pick_vec;
    oreg_t          o_d, o_q;

    xpose_pp_seq #(.N(N), .CW(CW)) seq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (in_valid),
        .lane   (lane),
        .ori    (ori),
        .primed (primed)
    );

    genvar gi, gj;
    generate
        for (gi = 0; gi < N; gi++) begin : g_r
            for (gj = 0; gj < N; gj++) begin : g_c
                logic we;
                assign we = in_valid &&
                    ((ori == ORI_COL) ? (lane == CW'(gj)) : (lane == CW'(gi)));
                xpose_pp_cell #(.W(W)) cell_i (
                    .clk         (clk),
                    .rst_n       (rst_n),
                    .we          (we),
                    .ori         (ori),
                    .by_row_lane (in_data[gi*W +: W]),
                    .by_col_lane (in_data[gj*W +: W]),
                    .q           (cell_q[gi][gj])
                );
            end
        end

        for (gi = 0; gi < N; gi++) begin : g_o
            logic [N*W-1:0] rc, cc;
            for (gj = 0; gj < N; gj++) begin : g_tap
                assign rc[gj*W +: W] = cell_q[gi][gj];
                assign cc[gj*W +: W] = cell_q[gj][gi];
            end
            xpose_pp_pick #(.N(N), .W(W), .I(gi), .CW(CW)) pick_i (
                .row_cells (rc),
                .col_cells (cc),
                .lane      (lane),
                .ori       (ori),
                .q         (pick_vec[gi*W +: W])
            );
        end
    endgenerate

    always_comb begin
        o_d     = o_q;
        o_d.vld = in_valid && primed;
        if (in_valid && primed) begin
            o_d.dat = pick_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign out_valid = o_q.vld;
    assign out_data  = o_q.dat;

endmodule

// File: rtl/xpose_pp_chk.sv
module xpose_pp_chk #(
    parameter int N = 4,
    parameter int W = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic [N*W-1:0] out_data,
    input logic           out_valid
);

    localparam int SW = $clog2(N + 2);
    localparam logic [SW-1:0] FULL = SW'(N);

    logic [SW-1:0] seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (in_valid && seen_q != FULL) begin
            seen_q <= seen_q + 1'b1;
        end
    end

    // R2
    fill_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && seen_q != FULL) |=> !out_valid);

    // R8
    steady_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && seen_q == FULL) |=> out_valid);

    // R5
    idle_novalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));

    // R1
    always_ff @(posedge clk) begin
        if (rst_n && seen_q == '0) begin
            reset_quiet_chk: assert (!out_valid);
        end
    end

endmodule

bind xpose_pp_top xpose_pp_chk #(.N(N), .W(W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_data  (out_data),
    .out_valid (out_valid)
);

// File: tb/xpose_pp_tb.sv
`timescale 1ns/1ps
module xpose_pp_top_tb_top;

    localparam int N = 4;
    localparam int W = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic [N*W-1:0] in_data = '0;
    logic           out_valid;
    logic [N*W-1:0] out_data;

    int total = 0;
    int bad = 0;

    logic [N*W-1:0] hist [256];
    int acc = 0;
    int produced = 0;
    logic [N*W-1:0] last_out = '0;

    always #5 clk = ~clk;

    xpose_pp_top #(.N(N), .W(W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    task automatic check(string req, logic [N*W-1:0] act, logic [N*W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [N*W-1:0] expect_vec(int o);
        logic [N*W-1:0] v;
        int b = o / N;
        int k = o % N;
        for (int i = 0; i < N; i++) begin
            v[i*W +: W] = hist[b*N + i][k*W +: W];
        end
        return v;
    endfunction

    task automatic step(string req, logic v, logic [N*W-1:0] d);
        logic ev;
        @(negedge clk);
        in_valid = v;
        in_data  = d;
        @(posedge clk);
        #1;
        if (v) begin
            ev = (acc >= N);
            hist[acc % 256] = d;
            acc++;
        end else begin
            ev = 1'b0;
        end
        check(req, {{(N*W-1){1'b0}}, out_valid}, {{(N*W-1){1'b0}}, ev});
        if (ev) begin
            last_out = expect_vec(produced);
            produced++;
        end
        check(req, out_data, last_out);
    endtask

    function automatic logic [N*W-1:0] mk(int seed, int n);
        logic [N*W-1:0] v;
        for (int i = 0; i < N; i++) begin
            v[i*W +: W] = W'(n * 13 + i * 5 + seed * 31 + 1);
        end
        return v;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        acc = 0;
        produced = 0;
        last_out = '0;
    endtask

    task automatic t_reset_state();
        do_reset();
        #1;
        check("R1", {{(N*W-1){1'b0}}, out_valid}, '0);
        check("R1", out_data, '0);
    endtask

    task automatic t_fill();
        for (int n = 0; n < N; n++) step("R2", 1'b1, mk(1, n));
        step("R2", 1'b1, mk(1, N));
    endtask

    task automatic t_stream();
        for (int n = 0; n < 4 * N; n++) step("R4", 1'b1, mk(2, n));
        for (int n = 0; n < 2 * N; n++) step("R3", 1'b1, mk(3, n));
    endtask

    task automatic t_stall();
        for (int n = 0; n < 3 * N; n++) begin
            step("R3", 1'b1, mk(4, n));
            if (n % 3 == 1) begin
                step("R5", 1'b0, mk(9, n));
                step("R6", 1'b0, '1);
            end
        end
    endtask

    task automatic t_mid_reset();
        for (int n = 0; n < N + 2; n++) step("R8", 1'b1, mk(5, n));
        do_reset();
        #1;
        check("R7", {{(N*W-1){1'b0}}, out_valid}, '0);
        for (int n = 0; n < N + 1; n++) step("R7", 1'b1, mk(6, n));
        for (int n = 0; n < 2 * N; n++) step("R3", 1'b1, mk(7, n));
    endtask

    initial begin
        t_reset_state();
        t_fill();
        t_stream();
        t_stall();
        t_mid_reset();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule